// File: doc/BRIEF.md
# Bypass-Limited Three-Class Request Arbiter

This block chooses, every cycle, which of several memory-access requesters is served. Each requester presents a valid bit and a two-bit access type: a processor read, a write with a timing guarantee (isochronous), or an ordinary write. Configuration bits turn each access type into one of three service classes: high, medium or low. The winning class is served first. Requesters inside one class take turns in round-robin order.

A higher class may not starve the classes below it. The high class carries a small counter of how many times it has won while a medium or low request was waiting. The medium class carries the same kind of counter against waiting low requests. Each counter is compared with a programmable limit. Once a class has reached its limit while a lower class is waiting, that class loses the next arbitration, and the waiting lower class is served instead. Serving a lower class resets the counter.

The interface follows valid/ready rules. `req_valid[i]` is the valid signal of requester i, and `grant[i]` is its ready, given in the same cycle. A requester keeps its valid bit and its type steady until the cycle in which it is granted. The handshake completes on the rising clock edge of a cycle in which both are high. A requester that is not granted is simply back-pressured: it keeps waiting and loses nothing. The configuration pins are plain levels.

Top module: `prio_bypass_arb`

## Requirements
- R1: At most one bit of `grant` is high in any cycle. A grant bit is only high for a requester whose `req_valid` is high. With no valid request, `grant` is all zero.
- R2: A type of 00 (processor read) belongs to the high class when `cfg_rd_high` is 1 and to the medium class when it is 0.
- R3: A type of 10 or 11 (ordinary write) belongs to the low class when `cfg_wr_medium` is 0 and to the medium class when it is 1.
- R4: A type of 01 (isochronous write) belongs to the high class when `cfg_iso_drop` is 0, whatever `cfg_iso_drop_more` is. With `cfg_iso_drop` at 1 it belongs to the medium class, or to the low class if `cfg_iso_drop_more` is also 1.
- R5: While neither bypass counter has reached its limit, the grant goes to the highest class that has a valid request.
- R6: When the high counter is at or above `cfg_high_limit` and a medium or low request is waiting, no high request is granted in that cycle. With a limit of L, a steady high request and a steady low request receive L high grants, then one low grant, and the pattern repeats. A limit of 0 lets every waiting lower request go first.
- R7: When the medium counter is at or above `cfg_med_limit` and a low request is waiting, no medium request is granted in that cycle. Under steady medium and low requests, the pattern is L medium grants, then one low grant.
- R8: The high counter counts up only when a high request is granted while a lower class waits, and it returns to 0 when a medium or low request is granted. The medium counter counts up only when a medium request is granted while a low request waits, and it returns to 0 when a low request is granted. In a cycle with no valid request, both counters hold their values.
- R9: Inside one class, after requester i has been granted, the next grant in that class goes to the first valid requester of that class found by searching upward from index i+1 and wrapping around.
- R10: Reset clears both counters and points every class at requester 0, so the first grant in any class goes to its lowest-indexed valid requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester valid (request pending) |
| req_type | input | 2*NREQ | Access type of requester i in bits [2i+1:2i]: 00 read, 01 isochronous write, 1x ordinary write |
| cfg_rd_high | input | 1 | Processor reads are high class when set, medium when clear |
| cfg_wr_medium | input | 1 | Ordinary writes are medium class when set, low when clear |
| cfg_iso_drop | input | 1 | Moves isochronous writes down from high to medium |
| cfg_iso_drop_more | input | 1 | Together with `cfg_iso_drop`, moves isochronous writes to low |
| cfg_high_limit | input | LIMW | Number of times the high class may overtake before it yields |
| cfg_med_limit | input | LIMW | Number of times the medium class may overtake low before it yields |
| grant | output | NREQ | One-hot (or zero) grant, acting as per-requester ready |

## Verification
`grant` is a combinational function of the current requests, the configuration and the registered state, so it is due in the same cycle as the stimulus. The counters and round-robin pointers change on the next rising edge, so their effect first shows in the grant of the following cycle. The bench applies each cycle's inputs just after a falling edge and samples `grant` 2 ns later, which is well before the next rising edge. Only after that edge does it advance its own model of the counters and pointers. Every check therefore compares a grant against the model state that was correct for that cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    CLS_LO  = 2'd0,
    CLS_MED = 2'd1,
    CLS_HI  = 2'd2
  } cls_e;

  localparam int NCLS    = 3;
  localparam int IDX_LO  = 0;
  localparam int IDX_MED = 1;
  localparam int IDX_HI  = 2;

  localparam logic [1:0] TY_READ = 2'b00;
  localparam logic [1:0] TY_ISO  = 2'b01;
endpackage

// File: rtl/arb_classify.sv
module arb_classify #(
  parameter int NREQ = 4
) (
  input  logic [2*NREQ-1:0] req_type,
  input  logic              cfg_rd_high,
  input  logic              cfg_wr_medium,
  input  logic              cfg_iso_drop,
  input  logic              cfg_iso_drop_more,
  output logic [2*NREQ-1:0] req_cls
);
  import arb_pkg::*;

  for (genvar i = 0; i < NREQ; i++) begin : g_map
    logic [1:0] ty;
    cls_e       cls;
    assign ty = req_type[2*i +: 2];
    always_comb begin
      if (ty == TY_READ) begin
        cls = cfg_rd_high ? CLS_HI : CLS_MED;          // R2
      end else if (ty == TY_ISO) begin
        if (!cfg_iso_drop)          cls = CLS_HI;       // R4
        else if (cfg_iso_drop_more) cls = CLS_LO;
        else                        cls = CLS_MED;
      end else begin
        cls = cfg_wr_medium ? CLS_MED : CLS_LO;        // R3
      end
    end
    assign req_cls[2*i +: 2] = cls;
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            adv,
  output logic [NREQ-1:0] gnt
);
  localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] pick;
  logic [PW-1:0] pick_next;
  logic          found;
  int            slot;

  always_comb begin
    gnt   = '0;
    pick  = ptr;
    found = 1'b0;
    slot  = 0;
    for (int k = 0; k < NREQ; k++) begin
      slot = int'(ptr) + k;
      if (slot >= NREQ) slot = slot - NREQ;
      if (!found && req[slot]) begin
        found = 1'b1;
        pick  = PW'(slot);
      end
    end
    if (found) gnt[pick] = 1'b1;
    pick_next = (int'(pick) == NREQ - 1) ? '0 : pick + 1'b1;
  end

  // R9 / R10: pointer moves just past the served requester
  always_ff @(posedge clk) begin
    if (!rst_n)            ptr <= '0;
    else if (adv && found) ptr <= pick_next;
  end
endmodule

// File: rtl/arb_bypass_ctr.sv
module arb_bypass_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win,
  input  logic         yield,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;

  // R8: count overtakes, clear when a lower class is served
  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (yield)                cnt <= '0;
    else if (win && cnt != CMAX)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prio_bypass_arb.sv
module prio_bypass_arb #(
  parameter int NREQ = 4,
  parameter int LIMW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [2*NREQ-1:0] req_type,
  input  logic              cfg_rd_high,
  input  logic              cfg_wr_medium,
  input  logic              cfg_iso_drop,
  input  logic              cfg_iso_drop_more,
  input  logic [LIMW-1:0]   cfg_high_limit,
  input  logic [LIMW-1:0]   cfg_med_limit,
  output logic [NREQ-1:0]   grant
);
  import arb_pkg::*;

  logic [2*NREQ-1:0] req_cls;
  logic [NREQ-1:0]   cmask [NCLS];
  logic [NREQ-1:0]   cgnt  [NCLS];
  logic [NCLS-1:0]   cany;
  logic [NCLS-1:0]   cadv;
  logic [LIMW-1:0]   hi_cnt;
  logic [LIMW-1:0]   med_cnt;
  logic              lower_than_hi;
  logic              hi_stop;
  logic              med_stop;

  arb_classify #(.NREQ(NREQ)) u_cls (
    .req_type          (req_type),
    .cfg_rd_high       (cfg_rd_high),
    .cfg_wr_medium     (cfg_wr_medium),
    .cfg_iso_drop      (cfg_iso_drop),
    .cfg_iso_drop_more (cfg_iso_drop_more),
    .req_cls           (req_cls)
  );

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      for (int i = 0; i < NREQ; i++) begin
        cmask[c][i] = req_valid[i] && (req_cls[2*i +: 2] == 2'(c));
      end
      cany[c] = |cmask[c];
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_rr
    arb_rr_pick #(.NREQ(NREQ)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cmask[c]),
      .adv   (cadv[c]),
      .gnt   (cgnt[c])
    );
  end

  assign lower_than_hi = cany[IDX_MED] || cany[IDX_LO];
  assign hi_stop  = (hi_cnt  >= cfg_high_limit) && lower_than_hi;   // R6
  assign med_stop = (med_cnt >= cfg_med_limit)  && cany[IDX_LO];    // R7

  // R5: class choice, highest class that is not suspended
  always_comb begin
    cadv = '0;
    if (cany[IDX_HI] && !hi_stop)        cadv[IDX_HI]  = 1'b1;
    else if (cany[IDX_MED] && !med_stop) cadv[IDX_MED] = 1'b1;
    else if (cany[IDX_LO])               cadv[IDX_LO]  = 1'b1;
  end

  always_comb begin
    if (cadv[IDX_HI])       grant = cgnt[IDX_HI];
    else if (cadv[IDX_MED]) grant = cgnt[IDX_MED];
    else if (cadv[IDX_LO])  grant = cgnt[IDX_LO];
    else                    grant = '0;
  end

  arb_bypass_ctr #(.W(LIMW)) u_hi_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .win   (cadv[IDX_HI] && lower_than_hi),
    .yield (cadv[IDX_MED] || cadv[IDX_LO]),
    .cnt   (hi_cnt)
  );

  arb_bypass_ctr #(.W(LIMW)) u_med_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .win   (cadv[IDX_MED] && cany[IDX_LO]),
    .yield (cadv[IDX_LO]),
    .cnt   (med_cnt)
  );
endmodule

// File: rtl/prio_bypass_arb_chk.sv
module prio_bypass_arb_chk #(
  parameter int NREQ = 4,
  parameter int LIMW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREQ-1:0]   req_valid,
  input logic [NREQ-1:0]   grant,
  input logic [2*NREQ-1:0] req_cls,
  input logic [LIMW-1:0]   hi_cnt,
  input logic [LIMW-1:0]   med_cnt,
  input logic [LIMW-1:0]   hi_lim,
  input logic [LIMW-1:0]   med_lim
);
  logic [1:0] g_cls;
  logic       any_med, any_lo;

  always_comb begin
    g_cls   = 2'd0;
    any_med = 1'b0;
    any_lo  = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) g_cls = req_cls[2*i +: 2];
      if (req_valid[i] && req_cls[2*i +: 2] == 2'd1) any_med = 1'b1;
      if (req_valid[i] && req_cls[2*i +: 2] == 2'd0) any_lo  = 1'b1;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_gnt_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (grant == '0));

  p_hi_yield_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_cnt >= hi_lim) && (any_med || any_lo)) |-> !((|grant) && g_cls == 2'd2));

  p_med_yield_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((med_cnt >= med_lim) && any_lo) |-> !((|grant) && g_cls == 2'd1));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |=> ($stable(hi_cnt) && $stable(med_cnt)));

  p_hi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && g_cls != 2'd2) |=> (hi_cnt == '0));
endmodule

bind prio_bypass_arb prio_bypass_arb_chk #(.NREQ(NREQ), .LIMW(LIMW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .grant     (grant),
  .req_cls   (req_cls),
  .hi_cnt    (hi_cnt),
  .med_cnt   (med_cnt),
  .hi_lim    (cfg_high_limit),
  .med_lim   (cfg_med_limit)
);

// File: tb/prio_bypass_arb_test.sv
module prio_bypass_arb_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_type = '0;
  logic cfg_rd_high = 0, cfg_wr_medium = 0, cfg_iso_drop = 0, cfg_iso_drop_more = 0;
  logic [1:0] cfg_high_limit = 2'd3, cfg_med_limit = 2'd3;
  logic [N-1:0] grant;

  // staged stimulus, applied after a falling edge
  logic [N-1:0]   s_valid = '0;
  logic [2*N-1:0] s_type  = '0;
  logic s_rd = 0, s_wm = 0, s_d1 = 0, s_d2 = 0;
  logic [1:0] s_hl = 2'd3, s_ml = 2'd3;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] last_g;

  // reference state
  int m_hi, m_med;
  int m_ptr [3];

  always #5 clk = ~clk;

  prio_bypass_arb #(.NREQ(N), .LIMW(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .cfg_rd_high(cfg_rd_high), .cfg_wr_medium(cfg_wr_medium),
    .cfg_iso_drop(cfg_iso_drop), .cfg_iso_drop_more(cfg_iso_drop_more),
    .cfg_high_limit(cfg_high_limit), .cfg_med_limit(cfg_med_limit),
    .grant(grant)
  );

  function automatic int cls_of(logic [1:0] ty);
    if (ty == 2'b00) return cfg_rd_high ? 2 : 1;
    if (ty == 2'b01) return !cfg_iso_drop ? 2 : (cfg_iso_drop_more ? 0 : 1);
    return cfg_wr_medium ? 1 : 0;
  endfunction

  function automatic void model(output logic [N-1:0] g, output int sel, output bit [2:0] any);
    int cl [N];
    any = '0;
    g = '0;
    sel = -1;
    for (int i = 0; i < N; i++) begin
      cl[i] = cls_of(req_type[2*i +: 2]);
      if (req_valid[i]) any[cl[i]] = 1'b1;
    end
    if (any[2] && !(m_hi >= int'(cfg_high_limit) && (any[1] || any[0]))) sel = 2;
    else if (any[1] && !(m_med >= int'(cfg_med_limit) && any[0])) sel = 1;
    else if (any[0]) sel = 0;
    if (sel >= 0) begin
      for (int k = N - 1; k >= 0; k--) begin
        int j;
        j = (m_ptr[sel] + k) % N;
        if (req_valid[j] && cl[j] == sel) g = N'(1) << j;
      end
    end
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req);
    logic [N-1:0] eg;
    int sel;
    bit [2:0] any;
    @(negedge clk);
    req_valid = s_valid; req_type = s_type;
    cfg_rd_high = s_rd; cfg_wr_medium = s_wm; cfg_iso_drop = s_d1; cfg_iso_drop_more = s_d2;
    cfg_high_limit = s_hl; cfg_med_limit = s_ml;
    #2;
    model(eg, sel, any);
    check(req, grant, eg);
    last_g = grant;
    @(posedge clk);
    if (sel == 2) begin
      if (any[1] || any[0]) m_hi++;
    end else if (sel >= 0) begin
      m_hi = 0;
      if (sel == 1 && any[0]) m_med++;
      if (sel == 0) m_med = 0;
    end
    if (sel >= 0) begin
      for (int i = 0; i < N; i++) if (eg[i]) m_ptr[sel] = (i + 1) % N;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_valid = '0; s_type = '0;
    s_rd = 0; s_wm = 0; s_d1 = 0; s_d2 = 0; s_hl = 2'd3; s_ml = 2'd3;
    req_valid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_hi = 0; m_med = 0;
    for (int c = 0; c < 3; c++) m_ptr[c] = 0;
  endtask

  task automatic put(input int i, input logic [1:0] ty);
    s_valid[i] = 1'b1;
    s_type[2*i +: 2] = ty;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R10 / R1: idle after reset, then lowest index first
    step("R1 idle");
    check("R10 reset grant", grant, 4'b0000);
    for (int i = 0; i < N; i++) put(i, 2'b10);
    step("R10 first grant");
    check("R10 lowest index", last_g, 4'b0001);

    // R9: rotation inside one class
    for (int r = 0; r < 5; r++) step("R9 rotate");
    do_reset();
    put(1, 2'b10); put(3, 2'b11);
    step("R9 sparse"); step("R9 sparse"); step("R9 sparse");

    // R2: read at index 1 vs medium write at index 0
    do_reset();
    s_wm = 1; put(0, 2'b10); put(1, 2'b00);
    s_rd = 1; step("R2 read high");
    check("R2 read high explicit", last_g, 4'b0010);
    do_reset();
    s_wm = 1; put(0, 2'b10); put(1, 2'b00);
    s_rd = 0; step("R2 read medium");
    check("R2 read medium explicit", last_g, 4'b0001);

    // R3: ordinary write vs medium read
    do_reset();
    put(0, 2'b11); put(1, 2'b00);
    step("R3 write low");
    check("R3 write low explicit", last_g, 4'b0010);

    // R4: isochronous write at index 2 vs medium read at 0 and low write at 1
    for (int m = 0; m < 4; m++) begin
      do_reset();
      s_d1 = m[0]; s_d2 = m[1];
      put(0, 2'b00); put(1, 2'b10); put(2, 2'b01);
      step("R4 iso class");
      step("R4 iso class");
    end

    // R5: all three classes waiting, limits not reached
    do_reset();
    put(0, 2'b10); put(1, 2'b00); put(2, 2'b01);
    step("R5 high first");
    check("R5 high explicit", last_g, 4'b0100);

    // R6: high limit 2, then 0
    do_reset();
    s_hl = 2'd2; put(0, 2'b01); put(1, 2'b10);
    for (int r = 0; r < 6; r++) step("R6 high limit 2");
    do_reset();
    s_hl = 2'd0; put(0, 2'b01); put(1, 2'b10);
    for (int r = 0; r < 3; r++) step("R6 high limit 0");
    check("R6 limit 0 explicit", last_g, 4'b0010);

    // R7: medium limit 1
    do_reset();
    s_ml = 2'd1; put(0, 2'b00); put(1, 2'b10);
    for (int r = 0; r < 4; r++) step("R7 medium limit 1");
    check("R7 pattern explicit", last_g, 4'b0010);

    // R8: counter holds across idle and across lone high grants
    do_reset();
    s_hl = 2'd1; put(0, 2'b01); put(1, 2'b10);
    step("R8 high overtakes");
    s_valid = '0; step("R8 idle"); step("R8 idle");
    put(0, 2'b01); put(1, 2'b10);
    step("R8 held count");
    check("R8 held count explicit", last_g, 4'b0010);
    s_valid = '0; put(0, 2'b01);
    step("R8 high alone"); step("R8 high alone");
    put(1, 2'b10);
    step("R8 after clear");
    check("R8 cleared explicit", last_g, 4'b0001);

    // constrained random, requests held until granted
    do_reset();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 250 == 0) begin
        s_rd = 1'($urandom); s_wm = 1'($urandom);
        s_d1 = 1'($urandom); s_d2 = 1'($urandom);
        s_hl = 2'($urandom); s_ml = 2'($urandom);
      end
      for (int i = 0; i < N; i++) begin
        if (!s_valid[i] && ($urandom % 3 != 0)) put(i, 2'($urandom));
      end
      if (cyc % 97 == 0) s_valid = '0;
      step("R5 R6 R7 R9 random");
      for (int i = 0; i < N; i++) if (last_g[i]) s_valid[i] = 1'b0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule